// File: doc/BRIEF.md
# Watchdog and Power-On Reset Supervisor

This block produces the reset request for a host processor. The request is active low and is meant to drive an open-drain pad: the pad's pull-down enable and the resulting pin level are both provided. Three events assert the reset. The first is the block's own power-on reset. The second is a digital low-voltage flag from an external comparator. The third is expiry of a watchdog that the host must restart regularly.

After each cause has gone away, the reset stays asserted for a fixed stretch of 250 ticks. All timing counts a 1 kHz tick strobe derived from the 32.768 kHz reference, so one tick is one millisecond.

The watchdog period comes from a two-bit select:

| Code | Period |
|------|--------|
| 00 (default) | 1750 ticks |
| 01 | 750 ticks |
| 10 | 250 ticks |
| 11 | watchdog disabled |

The host restarts the count with a single-cycle kick strobe, which stands in for activity on the host bus.

Top module: `rst_supervisor`

## Requirements
- R1: While `rst_ni` is low, `rst_n_o` is 0 and `rst_oe_o` is 1.
- R2: After `rst_ni` goes high, the reset stays asserted for exactly 250 ticks. It releases on the clock edge that samples the 250th tick.
- R3: With no kick, the watchdog asserts reset on the edge that samples its Nth tick after the release. N is 1750 for select 00, 750 for select 01 and 250 for select 10.
- R4: With select 11, the watchdog never asserts reset, however many ticks pass.
- R5: A high `lowv_i` asserts reset on the next clock edge. Reset then stays asserted for as long as the flag stays high.
- R6: After `lowv_i` falls, reset is released on the edge that samples the 250th tick after the fall.
- R7: After a watchdog expiry, reset is held for 250 ticks. The watchdog count then restarts from zero, so the next expiry takes a full period.
- R8: A kick while reset is released clears the watchdog count, so the period is counted again from the kick.
- R9: A kick while reset is asserted is ignored. It neither shortens nor lengthens the reset stretch.
- R10: `rst_oe_o` is 1 exactly when `rst_n_o` is 0. Every change of these outputs is registered: it appears one clock after the sampled cause.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, active low |
| tick_i | input | 1 | Single-cycle strobe at the 1 kHz time base |
| lowv_i | input | 1 | Low-voltage comparator flag, high when the supply is below the trip point |
| wd_sel_i | input | 2 | Watchdog period select (see the table above) |
| kick_i | input | 1 | Single-cycle watchdog restart strobe |
| rst_n_o | output | 1 | Reset request level, 0 = asserted |
| rst_oe_o | output | 1 | Pull-down enable for the open-drain reset pad |

## Verification
The assertions take `tick_i` and `kick_i` to be clean strobes that are synchronous to `clk_i`. They take `lowv_i` to be already synchronised. They take `wd_sel_i` to change only while the watchdog count is below the new period. The stimulus meets all of this in the following ways:
- It raises each tick for one cycle, with three idle cycles after it.
- It gives each kick a cycle of its own, away from the ticks.
- It changes the select only just after a reset release, when the count is zero.

// File: rtl/sup_pkg.sv
package sup_pkg;

  typedef enum logic [1:0] {
    SEL_LONG  = 2'b00,
    SEL_MID   = 2'b01,
    SEL_SHORT = 2'b10,
    SEL_OFF   = 2'b11
  } wd_sel_e;

  // Number of ticks before expiry for a select code; 0 when disabled.
  function automatic int unsigned wd_limit(logic [1:0] sel,
                                           int unsigned long_t,
                                           int unsigned mid_t,
                                           int unsigned short_t);
    case (sel)
      SEL_LONG:  return long_t;
      SEL_MID:   return mid_t;
      SEL_SHORT: return short_t;
      default:   return 0;
    endcase
  endfunction

  function automatic logic wd_enabled(logic [1:0] sel);
    return sel != SEL_OFF;
  endfunction

endpackage

// File: rtl/sup_watchdog.sv
module sup_watchdog #(
  parameter int unsigned LONG_TICKS  = 1750,
  parameter int unsigned MID_TICKS   = 750,
  parameter int unsigned SHORT_TICKS = 250,
  localparam int unsigned CW = $clog2(LONG_TICKS + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       kick_i,
  input  logic [1:0] sel_i,
  input  logic       hold_i,
  output logic       expire_o
);
  import sup_pkg::*;

  logic [CW-1:0] cnt_q;
  int unsigned   limit;
  logic          enabled;
  logic          at_limit;
  logic          clear;

  always_comb begin
    limit    = wd_limit(sel_i, LONG_TICKS, MID_TICKS, SHORT_TICKS);
    enabled  = wd_enabled(sel_i);
    at_limit = (32'(cnt_q) + 32'd1) >= limit;
    clear    = hold_i | kick_i | ~enabled;
    expire_o = tick_i & ~clear & at_limit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clear)    cnt_q <= '0;
    else if (tick_i)   cnt_q <= expire_o ? '0 : cnt_q + CW'(1);
  end

  // R3
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(cnt_q) < LONG_TICKS);

  // R7
  wd_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hold_i) |-> (cnt_q == '0));

endmodule

// File: rtl/sup_stretch.sv
module sup_stretch #(
  parameter int unsigned STRETCH_TICKS = 250,
  localparam int unsigned SW = $clog2(STRETCH_TICKS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic lowv_i,
  input  logic expire_i,
  output logic hold_o
);

  logic [SW-1:0] scnt_q;
  logic          last_tick;

  assign last_tick = tick_i && (scnt_q == SW'(STRETCH_TICKS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_o <= 1'b1;
      scnt_q <= '0;
    end else if (lowv_i) begin
      hold_o <= 1'b1;
      scnt_q <= '0;
    end else if (hold_o) begin
      if (last_tick) begin
        hold_o <= 1'b0;
        scnt_q <= '0;
      end else if (tick_i) begin
        scnt_q <= scnt_q + SW'(1);
      end
    end else if (expire_i) begin
      hold_o <= 1'b1;
      scnt_q <= '0;
    end
  end

  // R5
  lowv_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lowv_i |=> hold_o);

  // R6
  release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hold_o) |-> ($past(tick_i) && !$past(lowv_i) &&
                       ($past(scnt_q) == SW'(STRETCH_TICKS - 1))));

  // R10
  rise_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hold_o) |-> $past(lowv_i || expire_i));

endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
  parameter int unsigned LONG_TICKS    = 1750,
  parameter int unsigned MID_TICKS     = 750,
  parameter int unsigned SHORT_TICKS   = 250,
  parameter int unsigned STRETCH_TICKS = 250
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       lowv_i,
  input  logic [1:0] wd_sel_i,
  input  logic       kick_i,
  output logic       rst_n_o,
  output logic       rst_oe_o
);
  import sup_pkg::*;

  logic hold;
  logic wd_expire;

  sup_watchdog #(
    .LONG_TICKS (LONG_TICKS),
    .MID_TICKS  (MID_TICKS),
    .SHORT_TICKS(SHORT_TICKS)
  ) wd_u (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .kick_i  (kick_i),
    .sel_i   (wd_sel_i),
    .hold_i  (hold),
    .expire_o(wd_expire)
  );

  sup_stretch #(
    .STRETCH_TICKS(STRETCH_TICKS)
  ) st_u (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .lowv_i  (lowv_i),
    .expire_i(wd_expire),
    .hold_o  (hold)
  );

  assign rst_n_o  = ~hold;
  assign rst_oe_o = hold;

  // R4
  wd_off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wd_sel_i == SEL_OFF && !lowv_i && rst_n_o) |=> rst_n_o);

endmodule

// File: tb/rst_supervisor_tb_top.sv
module rst_supervisor_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       lowv = 1'b0;
  logic [1:0] sel = 2'b00;
  logic       kick = 1'b0;
  logic       rst_n_o, rst_oe_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  rst_supervisor dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .lowv_i(lowv),
    .wd_sel_i(sel), .kick_i(kick), .rst_n_o(rst_n_o), .rst_oe_o(rst_oe_o)
  );

  // Behavioural reference: state as integers, updated on each edge.
  int m_hold = 1, m_scnt = 0, m_wcnt = 0;

  function automatic int period(logic [1:0] s);
    if (s == 2'b00) return 1750;
    if (s == 2'b01) return 750;
    if (s == 2'b10) return 250;
    return -1;
  endfunction

  always @(posedge clk) begin
    int n_hold, n_scnt, n_wcnt;
    bit fire;
    if (!rst_n) begin
      m_hold = 1; m_scnt = 0; m_wcnt = 0;
    end else begin
      fire = tick && m_hold == 0 && period(sel) > 0 && !kick &&
             (m_wcnt + 1 >= period(sel));
      n_wcnt = m_wcnt;
      if (m_hold == 1 || kick || period(sel) < 0) n_wcnt = 0;
      else if (tick) n_wcnt = fire ? 0 : m_wcnt + 1;
      n_hold = m_hold; n_scnt = m_scnt;
      if (lowv) begin n_hold = 1; n_scnt = 0; end
      else if (m_hold == 1) begin
        if (tick) begin
          if (m_scnt == 249) begin n_hold = 0; n_scnt = 0; end
          else n_scnt = m_scnt + 1;
        end
      end else if (fire) begin n_hold = 1; n_scnt = 0; end
      m_hold = n_hold; m_scnt = n_scnt; m_wcnt = n_wcnt;
    end
  end

  // R10: compare against the reference on every cycle
  always @(negedge clk) begin
    checks++;
    if (rst_n_o !== (m_hold == 0) || rst_oe_o !== (m_hold == 1)) begin
      errors++;
      $display("FAIL R10 model: rst_n_o=%b rst_oe_o=%b expected %b %b",
               rst_n_o, rst_oe_o, m_hold == 0, m_hold == 1);
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: rst_n_o=%b expected %b", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
      @(negedge clk);
      @(negedge clk);
    end
  endtask

  task automatic pulse_kick();
    @(negedge clk) kick = 1'b1;
    @(negedge clk) kick = 1'b0;
  endtask

  task automatic run_all();
    repeat (3) @(negedge clk);
    chk("R1 reset level", rst_n_o, 1'b0);
    chk("R1 pad enable", rst_oe_o, 1'b1);
    rst_n = 1'b1;
    step(249);  chk("R2 held at 249", rst_n_o, 1'b0);
    step(1);    chk("R2 released at 250", rst_n_o, 1'b1);
    chk("R10 pad off", rst_oe_o, 1'b0);
    step(1749); chk("R3 code00 alive at 1749", rst_n_o, 1'b1);
    step(1);    chk("R3 code00 expiry", rst_n_o, 1'b0);
    step(249);  chk("R7 stretch held", rst_n_o, 1'b0);
    step(1);    chk("R7 stretch release", rst_n_o, 1'b1);
    sel = 2'b01;
    step(749);  chk("R3 code01 alive at 749", rst_n_o, 1'b1);
    step(1);    chk("R3 code01 expiry", rst_n_o, 1'b0);
    step(250);  chk("R7 release after code01", rst_n_o, 1'b1);
    sel = 2'b10;
    step(249);  chk("R7 full period, alive at 249", rst_n_o, 1'b1);
    step(1);    chk("R3 code10 expiry", rst_n_o, 1'b0);
    step(250);  chk("R7 release after code10", rst_n_o, 1'b1);
    step(200);  pulse_kick();
    step(200);  chk("R8 kick keeps alive", rst_n_o, 1'b1);
    step(49);   chk("R8 alive at 249 after kick", rst_n_o, 1'b1);
    step(1);    chk("R8 expiry 250 after kick", rst_n_o, 1'b0);
    step(100);  pulse_kick();
    step(149);  chk("R9 kick in reset, still held", rst_n_o, 1'b0);
    step(1);    chk("R9 release time unchanged", rst_n_o, 1'b1);
    sel = 2'b11;
    step(3000); chk("R4 disabled never expires", rst_n_o, 1'b1);
    @(negedge clk) lowv = 1'b1;
    @(negedge clk);
    chk("R5 immediate assert", rst_n_o, 1'b0);
    chk("R10 pad on", rst_oe_o, 1'b1);
    step(500);  chk("R5 held while low", rst_n_o, 1'b0);
    @(negedge clk) lowv = 1'b0;
    step(249);  chk("R6 held at 249", rst_n_o, 1'b0);
    step(1);    chk("R6 released at 250", rst_n_o, 1'b1);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule